// File: doc/BRIEF.md
# Prescaled Fan PWM Generator

This block drives one fan PWM pin from an 8-bit duty value and a free-running period counter of 256 steps. The counter does not advance on every system clock. It advances on a divided tick. That tick comes from one of two reference enable pulses, a fast one or one at an eighth of that rate, chosen by a select bit. A 7-bit prescale value then divides the chosen tick. Every counter runs in the system clock domain, and no derived clock is created.

Software reaches the block through a small register port with two addresses. One holds the duty value. The other holds the reference select and the prescale value. A fan-control engine outside the block can assert a smart-mode input and supply its own duty. When it does, that duty drives the output and is also what a duty readback returns. A new duty is taken up only at a period boundary, so a period that is already running never changes shape.

Top module: `fan_pwm_gen`

## Requirements
- R1: The period counter advances by one, modulo 256, on each divided tick and holds otherwise, so one PWM period lasts 256 divided ticks.
- R2: An active duty of 00h keeps `pwm_out` low for the whole period.
- R3: An active duty of FFh keeps `pwm_out` high for all 256 counts of the period.
- R4: For any other active duty XX, `pwm_out` is high while the counter value is below XX, giving XX high counts out of 256, starting at counter value 0.
- R5: A duty written or supplied during a period becomes active only when the counter wraps from 255 to 0.
- R6: Config bit 7 selects the reference: 0 counts `tick_fast` pulses, 1 counts `tick_slow` pulses.
- R7: Config bits 6:0 hold the prescale N. For N of 2 or more, one divided tick occurs on every Nth selected pulse. N of 0 or 1 passes every selected pulse straight through.
- R8: After a synchronous reset, the stored duty is FFh, the config register reads 01h, the counter is 0 and the active duty is FFh.
- R9: While `smart_en` is high, a duty readback returns `smart_duty`, and `smart_duty` is the value loaded at the next wrap. The stored duty stays unchanged and reads back again once `smart_en` falls.
- R10: Any write to the config address restarts the prescale divider from zero, so the next divided tick comes N selected pulses after the write.
- R11: Address 0 is the duty register and address 1 is the config register `{select, prescale}`. A write lands on the clock edge where `wr_en` is high, and `rd_data` shows the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_fast | input | 1 | Fast reference enable, one cycle wide |
| tick_slow | input | 1 | Slow (one-eighth) reference enable, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 duty, 1 config |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `reg_addr` |
| smart_en | input | 1 | Smart-mode duty override enable |
| smart_duty | input | 8 | Duty supplied by smart mode |
| pwm_out | output | 1 | Fan PWM output |

## Verification
Restarting the divider in the middle of a count is the hardest case to reach, because a config write only shows its effect as a shift in the phase of later divided ticks. The stimulus rewrites an unchanged prescale value a few cycles after a previous write, while selected pulses keep arriving. A per-clock reference model predicts the exact cycle of every counter step, so a divider that failed to restart would put `pwm_out` edges in the wrong cycle. Whole-period high counts are also totalled and checked against the duty at both reference rates and at prescale 0, 1, 2, 3 and 5.

// File: rtl/fan_pwm_pkg.sv
// Package fan_pwm_pkg
// Shared address encoding for the fan PWM generator register port.
// Assumes a one-bit address: duty at 0, config at 1.
package fan_pwm_pkg;
    typedef enum logic {
        FAN_ADDR_DUTY = 1'b0,
        FAN_ADDR_CFG  = 1'b1
    } fan_addr_e;
endpackage

// File: rtl/fan_pwm_regs.sv
// Module fan_pwm_regs
// Holds the duty register and the config register {select, prescale}.
// Produces the effective duty (smart override or stored) and the readback.
// Assumes the prescale field fills every config bit below the select bit.
module fan_pwm_regs #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              reg_addr,
    input  logic [DUTY_W-1:0] wr_data,
    input  logic              smart_en,
    input  logic [DUTY_W-1:0] smart_duty,
    output logic [DUTY_W-1:0] rd_data,
    output logic [DUTY_W-1:0] duty_eff,
    output logic              sel_slow,
    output logic [DUTY_W-2:0] prescale,
    output logic              cfg_wr
);
    import fan_pwm_pkg::*;

    localparam int PRE_W = DUTY_W - 1;
    localparam logic [PRE_W-1:0] PRE_RESET = PRE_W'(1);

    logic [DUTY_W-1:0] duty_q;
    logic              sel_q;
    logic [PRE_W-1:0]  pre_q;
    logic              duty_wr;

    // Decode which register a write targets
    always_comb begin
        duty_wr = wr_en && (fan_addr_e'(reg_addr) == FAN_ADDR_DUTY);
        cfg_wr  = wr_en && (fan_addr_e'(reg_addr) == FAN_ADDR_CFG);
    end

    // Stored duty register, full-on at reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q <= '1;
        end else if (duty_wr) begin
            duty_q <= wr_data;
        end
    end

    // Config register: fast reference, divide by one at reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            pre_q <= PRE_RESET;
        end else if (cfg_wr) begin
            sel_q <= wr_data[DUTY_W-1];
            pre_q <= wr_data[PRE_W-1:0];
        end
    end

    // Effective duty and readback mux
    always_comb begin
        duty_eff = smart_en ? smart_duty : duty_q;
        sel_slow = sel_q;
        prescale = pre_q;
        if (fan_addr_e'(reg_addr) == FAN_ADDR_DUTY) begin
            rd_data = duty_eff;
        end else begin
            rd_data = {sel_q, pre_q};
        end
    end

    AST_DUTY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !duty_wr |=> $stable(duty_q)) else $error("duty changed without write"); // R11
    AST_SMART_KEEPS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (smart_en && !wr_en) |=> $stable(duty_q)) else $error("smart mode touched store"); // R9
endmodule

// File: rtl/fan_pwm_prescaler.sv
// Module fan_pwm_prescaler
// Picks one of two reference enables and divides it by the prescale value.
// Emits a one-cycle count_tick per divided tick; prescale 0 or 1 bypasses.
// Assumes reference enables are single-cycle pulses in the clk domain.
module fan_pwm_prescaler #(
    parameter int PRE_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_fast,
    input  logic             tick_slow,
    input  logic             sel_slow,
    input  logic [PRE_W-1:0] prescale,
    input  logic             cfg_wr,
    output logic             count_tick
);
    logic [PRE_W-1:0] div_q;
    logic             sel_tick;
    logic             bypass;
    logic             div_last;

    // Reference selection and terminal-count detection
    always_comb begin
        sel_tick   = sel_slow ? tick_slow : tick_fast;
        bypass     = (prescale <= PRE_W'(1));
        div_last   = (div_q == prescale - PRE_W'(1));
        count_tick = sel_tick && (bypass || div_last);
    end

    // Divider counter, cleared by reset, config write or terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (cfg_wr) begin
            div_q <= '0;
        end else if (sel_tick && !bypass) begin
            div_q <= div_last ? '0 : div_q + PRE_W'(1);
        end
    end

    AST_FAST_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (count_tick && !sel_slow) |-> tick_fast) else $error("tick not from fast ref"); // R6
    AST_SLOW_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (count_tick && sel_slow) |-> tick_slow) else $error("tick not from slow ref"); // R6
    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !bypass |-> (div_q < prescale)) else $error("divider out of range"); // R7
    AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (div_q == '0)) else $error("divider not restarted"); // R10
endmodule

// File: rtl/fan_pwm_core.sv
// Module fan_pwm_core
// 256-step period counter and duty comparator producing the PWM output.
// The active duty is reloaded only when the counter wraps from max to 0.
// Assumes count_tick is a single-cycle enable.
module fan_pwm_core #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_tick,
    input  logic [DUTY_W-1:0] duty_eff,
    output logic              pwm_out
);
    localparam logic [DUTY_W-1:0] PHASE_MAX = '1;

    logic [DUTY_W-1:0] phase_q;
    logic [DUTY_W-1:0] duty_act_q;
    logic              wrap;

    // Period boundary detection
    always_comb begin
        wrap = count_tick && (phase_q == PHASE_MAX);
    end

    // Period counter steps once per divided tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (count_tick) begin
            phase_q <= phase_q + DUTY_W'(1);
        end
    end

    // Active duty latched at the start of each period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_act_q <= '1;
        end else if (wrap) begin
            duty_act_q <= duty_eff;
        end
    end

    // Comparator with all-ones forced fully high
    always_comb begin
        pwm_out = (&duty_act_q) || (phase_q < duty_act_q);
    end

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !count_tick |=> $stable(phase_q)) else $error("phase moved without tick"); // R1
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        count_tick |=> (phase_q == $past(phase_q) + DUTY_W'(1))) else $error("phase step wrong"); // R1
    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_act_q == '0) |-> !pwm_out) else $error("zero duty drove high"); // R2
    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (&duty_act_q) |-> pwm_out) else $error("full duty drove low"); // R3
    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(duty_act_q)) else $error("duty changed mid period"); // R5
endmodule

// File: rtl/fan_pwm_gen.sv
// Module fan_pwm_gen
// Top level of the prescaled fan PWM generator: register port, reference
// select and prescale divider, and the 256-step PWM core.
// Assumes all inputs are synchronous to clk; reset is synchronous active low.
module fan_pwm_gen #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_fast,
    input  logic              tick_slow,
    input  logic              wr_en,
    input  logic              reg_addr,
    input  logic [DUTY_W-1:0] wr_data,
    output logic [DUTY_W-1:0] rd_data,
    input  logic              smart_en,
    input  logic [DUTY_W-1:0] smart_duty,
    output logic              pwm_out
);
    localparam int PRE_W = DUTY_W - 1;

    logic [DUTY_W-1:0] duty_eff;
    logic              sel_slow;
    logic [PRE_W-1:0]  prescale;
    logic              cfg_wr;
    logic              count_tick;

    fan_pwm_regs #(.DUTY_W(DUTY_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .reg_addr   (reg_addr),
        .wr_data    (wr_data),
        .smart_en   (smart_en),
        .smart_duty (smart_duty),
        .rd_data    (rd_data),
        .duty_eff   (duty_eff),
        .sel_slow   (sel_slow),
        .prescale   (prescale),
        .cfg_wr     (cfg_wr)
    );

    fan_pwm_prescaler #(.PRE_W(PRE_W)) u_prescaler (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_fast  (tick_fast),
        .tick_slow  (tick_slow),
        .sel_slow   (sel_slow),
        .prescale   (prescale),
        .cfg_wr     (cfg_wr),
        .count_tick (count_tick)
    );

    fan_pwm_core #(.DUTY_W(DUTY_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_tick (count_tick),
        .duty_eff   (duty_eff),
        .pwm_out    (pwm_out)
    );
endmodule

// File: tb/fan_pwm_gen_bench.sv
// Bench for fan_pwm_gen: a behavioural per-clock model predicts pwm_out,
// whole-period high counts are totalled, and register readback is checked.
module fan_pwm_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_fast = 1'b0;
    logic       tick_slow = 1'b0;
    logic       wr_en = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       smart_en = 1'b0;
    logic [7:0] smart_duty = 8'h00;
    logic       pwm_out;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int periods_done = 0;
    bit done = 0;

    // reference model state
    int m_duty = 255, m_sel = 0, m_pre = 1, m_div = 0, m_phase = 0, m_act = 255;
    int obs_hi = 0;
    bit obs_valid = 0;

    fan_pwm_gen u_fan_pwm_gen (
        .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
        .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
        .smart_en(smart_en), .smart_duty(smart_duty), .pwm_out(pwm_out)
    );

    always #10 clk = ~clk; // 50 MHz

    // reference pulses: fast every 2 clocks, slow every 16
    always @(negedge clk) begin
        cyc++;
        tick_fast = (cyc % 2) == 0;
        tick_slow = (cyc % 16) == 0;
    end

    // model step and per-clock comparison, 5 ns after each rising edge
    always @(posedge clk) begin
        int st, cnt, eff, exp_pwm, n_div, n_phase, n_act;
        #5;
        if (!rst_n) begin
            m_duty = 255; m_sel = 0; m_pre = 1; m_div = 0; m_phase = 0; m_act = 255;
            obs_valid = 0;
        end else begin
            st  = m_sel ? tick_slow : tick_fast;
            cnt = st && (m_pre <= 1 || m_div == m_pre - 1);
            eff = smart_en ? smart_duty : m_duty;
            n_div = m_div; n_phase = m_phase; n_act = m_act;
            if (wr_en && reg_addr) n_div = 0;
            else if (st && m_pre > 1) n_div = (m_div == m_pre - 1) ? 0 : m_div + 1;
            if (cnt) begin
                if (m_phase == 255) n_act = eff;
                n_phase = (m_phase + 1) % 256;
            end
            if (wr_en && !reg_addr) m_duty = wr_data;
            if (wr_en && reg_addr) begin m_sel = wr_data[7]; m_pre = wr_data[6:0]; end
            m_div = n_div; m_phase = n_phase; m_act = n_act;
            exp_pwm = (m_act == 255) ? 1 : (m_phase < m_act);
            n_checks++;
            if (pwm_out !== exp_pwm[0]) begin
                n_fail++;
                $display("FAIL R1/R4/R6/R7/R10 pwm_out cycle %0d: got %0b expected %0d", cyc, pwm_out, exp_pwm);
            end
            // whole-period high-time totals (R2 R3 R4)
            if (cnt) begin
                if (m_phase == 0) begin obs_hi = pwm_out; obs_valid = 1; end
                else obs_hi += pwm_out;
                if (m_phase == 255 && obs_valid) begin
                    n_checks++;
                    if (obs_hi != ((m_act == 255) ? 256 : m_act)) begin
                        n_fail++;
                        $display("FAIL R2/R3/R4 period high count duty %0d: got %0d expected %0d",
                                 m_act, obs_hi, (m_act == 255) ? 256 : m_act);
                    end
                    periods_done++;
                end
            end
        end
    end

    task automatic write_reg(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_rd(input logic a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        n_checks++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s readback addr %0d: got %02h expected %02h", tag, a, rd_data, exp);
        end
    endtask

    task automatic wait_periods(input int n);
        int target;
        target = periods_done + n;
        while (periods_done < target && !done) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8 reset state, R11 map
        check_rd(1'b0, 8'hFF, "R8");
        check_rd(1'b1, 8'h01, "R8 R11");
        // R3 full duty at reset
        wait_periods(2);
        // R2 zero duty, R5 taken at next wrap
        write_reg(1'b0, 8'h00);
        check_rd(1'b0, 8'h00, "R11");
        wait_periods(3);
        // R7 bypass with prescale 0, R4 middle duty
        write_reg(1'b1, 8'h00);
        write_reg(1'b0, 8'h40);
        check_rd(1'b1, 8'h00, "R7");
        wait_periods(3);
        // R7 divide by 3
        write_reg(1'b1, 8'h03);
        write_reg(1'b0, 8'h80);
        wait_periods(3);
        // R6 slow reference, divide by 2
        write_reg(1'b1, 8'h82);
        write_reg(1'b0, 8'h01);
        check_rd(1'b1, 8'h82, "R6 R11");
        wait_periods(2);
        // R6 slow reference, divide by 1, near-full duty
        write_reg(1'b1, 8'h81);
        write_reg(1'b0, 8'hFE);
        wait_periods(2);
        // R9 smart override
        write_reg(1'b1, 8'h01);
        @(negedge clk);
        smart_duty = 8'h30; smart_en = 1'b1;
        check_rd(1'b0, 8'h30, "R9");
        wait_periods(3);
        smart_en = 1'b0;
        check_rd(1'b0, 8'hFE, "R9");
        // R10 restart divider mid count with unchanged prescale
        write_reg(1'b1, 8'h05);
        write_reg(1'b0, 8'h9C);
        repeat (3) @(negedge clk);
        write_reg(1'b1, 8'h05);
        repeat (5) @(negedge clk);
        write_reg(1'b1, 8'h05);
        wait_periods(2);
        finish_run();
    end
endmodule